// File: doc/BRIEF.md
# Opcode-Based Instruction Dispatcher

The dispatcher sits between an instruction producer and three execution engines: a load engine, a compute engine and a store engine. Each fixed-width instruction that arrives is decoded and placed into the queue of exactly one engine. The choice depends on the opcode field. For load instructions it also depends on the memory-type field. Loads that fill the input or weight buffers go to the load engine. Every other load goes to the compute engine, which also receives arithmetic, finish and unknown opcodes. Stores go to the store engine.

Each engine drains its own queue through a valid/ready handshake. Each queue keeps its instructions in arrival order and reports its empty flag and occupancy. The input side is valid/ready as well. An instruction is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops only when the queue that the presented instruction needs is full. While stalled, the instruction stays on the input, and the queues of the other engines keep draining. On each output, `*_valid` is high whenever the queue holds an entry. The head entry stays stable until the engine raises its ready.

Top module: `insn_router`

## Requirements
- R1: An opcode of GEMM (2) or ALU (4), read from bits [2:0], is placed in the compute queue.
- R2: A LOAD opcode (0) whose memory type (bits [9:7] by default) is weight (1) or input (2) is placed in the load queue.
- R3: A LOAD opcode with any other memory type (micro-op 0, accumulator 3, output 4, or 5 to 7) is placed in the compute queue.
- R4: A STORE opcode (1) is placed in the store queue whatever its memory type.
- R5: The FINISH opcode (3) and the unused opcodes 5, 6 and 7 are placed in the compute queue.
- R6: Each queue delivers its instructions unmodified and in the order in which they were accepted.
- R7: `in_ready` is low exactly when the queue selected by the presented instruction holds DEPTH entries. A stalled instruction is neither lost nor duplicated, and the other queues still accept and drain.
- R8: Each queue's count equals the number of instructions it has accepted minus the number it has delivered, and its empty flag is high exactly when that count is 0. After reset all counts are 0, all empty flags are high and `in_ready` is high.
- R9: An output's valid is high whenever its queue is non-empty, and its head stays stable while valid is high and ready is low. A push and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer has an instruction |
| in_ready | output | 1 | Dispatcher accepts the instruction this cycle |
| in_insn | input | INSN_W | Instruction word |
| ld_valid | output | 1 | Load queue head is valid |
| ld_ready | input | 1 | Load engine pops the head |
| ld_insn | output | INSN_W | Load queue head |
| ld_empty | output | 1 | Load queue empty |
| ld_count | output | clog2(DEPTH+1) | Load queue occupancy |
| cp_valid | output | 1 | Compute queue head is valid |
| cp_ready | input | 1 | Compute engine pops the head |
| cp_insn | output | INSN_W | Compute queue head |
| cp_empty | output | 1 | Compute queue empty |
| cp_count | output | clog2(DEPTH+1) | Compute queue occupancy |
| st_valid | output | 1 | Store queue head is valid |
| st_ready | input | 1 | Store engine pops the head |
| st_insn | output | INSN_W | Store queue head |
| st_empty | output | 1 | Store queue empty |
| st_count | output | clog2(DEPTH+1) | Store queue occupancy |

## Verification
A directed sweep sends every opcode combined with every memory type while all engines drain. This separates the load routes that depend on memory type from those that do not, and it confirms the compute fallback for FINISH and unknown codes. A second directed pattern fills the load queue with the engines held off. The ninth load must then stall, a store must still be accepted alongside it, and draining must release the held load. Random traffic with random engine readiness then mixes stalls, simultaneous push and pop, and long backlogs. Order and data are compared against per-engine reference queues.

// File: rtl/insn_route_pkg.sv
package insn_route_pkg;
  localparam int OP_W    = 3;
  localparam int MT_W    = 3;
  localparam int NUM_ENG = 3;

  typedef enum logic [1:0] {
    ENG_LOAD  = 2'd0,
    ENG_COMP  = 2'd1,
    ENG_STORE = 2'd2
  } engine_e;

  localparam logic [OP_W-1:0] OP_LOAD   = 3'd0;
  localparam logic [OP_W-1:0] OP_STORE  = 3'd1;
  localparam logic [OP_W-1:0] OP_GEMM   = 3'd2;
  localparam logic [OP_W-1:0] OP_FINISH = 3'd3;
  localparam logic [OP_W-1:0] OP_ALU    = 3'd4;

  localparam logic [MT_W-1:0] MT_UOP = 3'd0;
  localparam logic [MT_W-1:0] MT_WGT = 3'd1;
  localparam logic [MT_W-1:0] MT_INP = 3'd2;
  localparam logic [MT_W-1:0] MT_ACC = 3'd3;
  localparam logic [MT_W-1:0] MT_OUT = 3'd4;
endpackage

// File: rtl/route_decode.sv
module route_decode
  import insn_route_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [MT_W-1:0] mem_type,
  output engine_e         dest
);
  always_comb begin
    unique case (opcode)
      OP_LOAD:  dest = (mem_type == MT_INP || mem_type == MT_WGT) ? ENG_LOAD : ENG_COMP;
      OP_STORE: dest = ENG_STORE;
      default:  dest = ENG_COMP;  // GEMM, ALU, FINISH and unknown codes
    endcase
  end
endmodule

// File: rtl/route_fifo.sv
module route_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  output logic                       push_ready,
  input  logic [W-1:0]               push_data,
  output logic                       pop_valid,
  input  logic                       pop_ready,
  output logic [W-1:0]               pop_data,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_phase, rd_phase;
  logic          full, do_push, do_pop;

  assign empty      = (wr_ptr == rd_ptr) && (wr_phase == rd_phase);
  assign full       = (wr_ptr == rd_ptr) && (wr_phase != rd_phase);
  assign push_ready = !full;
  assign pop_valid  = !empty;
  assign pop_data   = mem[rd_ptr];
  assign do_push    = push_valid && !full;
  assign do_pop     = pop_ready && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      wr_phase <= 1'b0;
      rd_phase <= 1'b0;
      count    <= '0;
    end else begin
      if (do_push) begin
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        if (wr_ptr == LAST) wr_phase <= !wr_phase;
      end
      if (do_pop) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        if (rd_ptr == LAST) rd_phase <= !rd_phase;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  empty_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (count == '0));
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && !pop_ready |=> pop_valid && $stable(pop_data));
endmodule

// File: rtl/insn_router.sv
module insn_router
  import insn_route_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int OP_LSB = 0,
  parameter int MT_LSB = 7,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [INSN_W-1:0]          in_insn,
  output logic                       ld_valid,
  input  logic                       ld_ready,
  output logic [INSN_W-1:0]          ld_insn,
  output logic                       ld_empty,
  output logic [$clog2(DEPTH+1)-1:0] ld_count,
  output logic                       cp_valid,
  input  logic                       cp_ready,
  output logic [INSN_W-1:0]          cp_insn,
  output logic                       cp_empty,
  output logic [$clog2(DEPTH+1)-1:0] cp_count,
  output logic                       st_valid,
  input  logic                       st_ready,
  output logic [INSN_W-1:0]          st_insn,
  output logic                       st_empty,
  output logic [$clog2(DEPTH+1)-1:0] st_count
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [OP_W-1:0] opcode;
  logic [MT_W-1:0] mem_type;
  engine_e         dest;
  logic [1:0]      dest_idx;

  logic [NUM_ENG-1:0] q_push, q_room, q_pop, q_valid, q_empty;
  logic [INSN_W-1:0]  q_data  [NUM_ENG];
  logic [CW-1:0]      q_count [NUM_ENG];

  assign opcode   = in_insn[OP_LSB +: OP_W];
  assign mem_type = in_insn[MT_LSB +: MT_W];

  route_decode u_dec (
    .opcode  (opcode),
    .mem_type(mem_type),
    .dest    (dest)
  );

  assign dest_idx = dest;
  assign q_pop    = {st_ready, cp_ready, ld_ready};

  always_comb begin
    unique case (dest)
      ENG_LOAD:  in_ready = q_room[0];
      ENG_STORE: in_ready = q_room[2];
      default:   in_ready = q_room[1];
    endcase
  end

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_q
    assign q_push[g] = in_valid && (dest_idx == 2'(g));
    route_fifo #(.W(INSN_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_valid(q_push[g]),
      .push_ready(q_room[g]),
      .push_data (in_insn),
      .pop_valid (q_valid[g]),
      .pop_ready (q_pop[g]),
      .pop_data  (q_data[g]),
      .empty     (q_empty[g]),
      .count     (q_count[g])
    );
  end

  assign ld_valid = q_valid[0];
  assign ld_insn  = q_data[0];
  assign ld_empty = q_empty[0];
  assign ld_count = q_count[0];
  assign cp_valid = q_valid[1];
  assign cp_insn  = q_data[1];
  assign cp_empty = q_empty[1];
  assign cp_count = q_count[1];
  assign st_valid = q_valid[2];
  assign st_insn  = q_data[2];
  assign st_empty = q_empty[2];
  assign st_count = q_count[2];

  logic [NUM_ENG-1:0] q_acc;
  assign q_acc = q_push & q_room;

  // R2
  load_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_acc[0] |-> (opcode == OP_LOAD) && (mem_type == MT_INP || mem_type == MT_WGT));
  // R4
  store_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_acc[2] |-> opcode == OP_STORE);
  // R1
  comp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (opcode == OP_GEMM || opcode == OP_ALU) |-> q_acc[1]);
  // R7
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (ld_count == CW'(DEPTH) || cp_count == CW'(DEPTH) || st_count == CW'(DEPTH)));
  // R7
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_acc));
endmodule

// File: tb/insn_router_tb.sv
module insn_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_insn = '0;
  logic ld_valid, cp_valid, st_valid;
  logic ld_ready = 1'b0, cp_ready = 1'b0, st_ready = 1'b0;
  logic [31:0] ld_insn, cp_insn, st_insn;
  logic ld_empty, cp_empty, st_empty;
  logic [CW-1:0] ld_count, cp_count, st_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mq [3][$];

  always #(CLK_PERIOD/2) clk = !clk;

  insn_router dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_insn(ld_insn), .ld_empty(ld_empty), .ld_count(ld_count),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_insn(cp_insn), .cp_empty(cp_empty), .cp_count(cp_count),
    .st_valid(st_valid), .st_ready(st_ready), .st_insn(st_insn), .st_empty(st_empty), .st_count(st_count)
  );

  function automatic int exp_dest(logic [31:0] ins);
    logic [2:0] op = ins[2:0];
    logic [2:0] mt = ins[9:7];
    if (op == 3'd1) return 2;
    if (op == 3'd0 && (mt == 3'd1 || mt == 3'd2)) return 0;
    return 1;
  endfunction

  function automatic string req_of(logic [31:0] ins);
    logic [2:0] op = ins[2:0];
    logic [2:0] mt = ins[9:7];
    if (op == 3'd2 || op == 3'd4) return "R1";
    if (op == 3'd0 && (mt == 3'd1 || mt == 3'd2)) return "R2";
    if (op == 3'd0) return "R3";
    if (op == 3'd1) return "R4";
    return "R5";
  endfunction

  function automatic logic [31:0] mk(logic [2:0] op, logic [2:0] mt);
    return {$urandom() & 22'h3fffff, mt, 4'($urandom()), op} ;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] ins, input logic [2:0] rdy, output logic acc);
    logic [2:0] ov;
    logic [31:0] od [3];
    logic [CW-1:0] oc [3];
    logic [2:0] oe;
    @(negedge clk);
    in_valid = v; in_insn = ins;
    ld_ready = rdy[0]; cp_ready = rdy[1]; st_ready = rdy[2];
    #1;
    ov = {st_valid, cp_valid, ld_valid};
    oe = {st_empty, cp_empty, ld_empty};
    od[0] = ld_insn; od[1] = cp_insn; od[2] = st_insn;
    oc[0] = ld_count; oc[1] = cp_count; oc[2] = st_count;
    chk("R7 ready", 32'(in_ready), 32'(mq[exp_dest(ins)].size() < DEPTH));
    for (int e = 0; e < 3; e++) begin
      chk("R8 count", 32'(oc[e]), 32'(mq[e].size()));
      chk("R8 empty", 32'(oe[e]), 32'(mq[e].size() == 0));
      chk("R9 valid", 32'(ov[e]), 32'(mq[e].size() != 0));
      if (mq[e].size() != 0)
        chk($sformatf("R6 %s data q%0d", req_of(mq[e][0]), e), od[e], mq[e][0]);
    end
    acc = v && in_ready;
    for (int e = 0; e < 3; e++)
      if (ov[e] && rdy[e] && mq[e].size() != 0) void'(mq[e].pop_front());
    if (acc) mq[exp_dest(ins)].push_back(ins);
  endtask

  task automatic send(input logic [31:0] ins, input logic [2:0] rdy);
    logic acc;
    acc = 1'b0;
    while (!acc) step(1'b1, ins, rdy, acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic acc;
    logic pend;
    logic [31:0] cur;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8 reset state: empty, zero counts, ready high
    step(1'b0, 32'h0, 3'b000, acc);

    // R1 R2 R3 R4 R5 sweep: every opcode with every memory type, engines draining
    for (int op = 0; op < 8; op++)
      for (int mt = 0; mt < 8; mt++)
        send(mk(3'(op), 3'(mt)), 3'b111);
    repeat (3) step(1'b0, 32'h0, 3'b111, acc);

    // R7 fill the load queue with engines held off
    for (int i = 0; i < DEPTH; i++) send(mk(3'd0, 3'd2), 3'b000);
    cur = mk(3'd0, 3'd1);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, cur, 3'b000, acc);
      chk("R7 stall", 32'(acc), 32'd0);
    end
    // R7 store still accepted while load queue is full
    step(1'b1, mk(3'd1, 3'd2), 3'b000, acc);
    chk("R7 other queue", 32'(acc), 32'd1);
    // R7 released by a pop, held load then accepted once
    send(cur, 3'b001);
    for (int i = 0; i < 3 * DEPTH; i++) step(1'b0, 32'h0, 3'b111, acc);
    chk("R7 drained", 32'(mq[0].size() + mq[1].size() + mq[2].size()), 32'd0);

    // R6 R9 random traffic with random engine readiness
    pend = 1'b0; cur = '0;
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] rdy;
      if (!pend && ($urandom() % 4 != 0)) begin
        cur = mk(3'($urandom()), 3'($urandom()));
        pend = 1'b1;
      end
      rdy = {($urandom() % 3 != 0), ($urandom() % 2 != 0), ($urandom() % 3 == 0)};
      step(pend, cur, rdy, acc);
      if (acc) pend = 1'b0;
    end
    for (int i = 0; i < 3 * DEPTH; i++) step(1'b0, 32'h0, 3'b111, acc);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule